// File: doc/BRIEF.md
# SD Host Data FIFO with Watermarks and DMA Request

This block is the data buffer between the host side (processor bus or DMA engine) and the card-side data path of an SD/MMC host controller. Words enter through a push port and leave through a pop port. The head word is always visible on the read data output. A direction input selects the owner of each port. In the receive direction the card side pushes and the DMA side pops. In the transmit direction the DMA side pushes and the card side pops.

Two independent watermark thresholds let software choose when a burst of reads or writes is worthwhile. A burst-length code sets the size of each DMA request. The request is raised only when a whole burst of data (receive) or of free space (transmit) exists. The request is then held until that many acknowledge beats have been seen.

The block reports the occupancy count, full, empty, both watermark flags and a sticky error flag. The error flag covers both overrun and underrun. A synchronous clear input empties the buffer without touching the rest of the controller.

Top module: `sdh_data_fifo`

## Requirements
- R1: While reset is asserted and right after it, `occ` is 0, `empty` is 1, and `full`, `err_flag` and `dma_req` are 0.
- R2: Words leave in the order they were accepted. `rd_data` shows the oldest stored word whenever `empty` is 0. `occ` rises by one for each accepted push, falls by one for each accepted pop, and is unchanged when a push and a pop are accepted in the same cycle.
- R3: `full` is 1 exactly when `occ` equals DEPTH. `empty` is 1 exactly when `occ` is 0.
- R4: `rx_wm` is 1 when `occ` is strictly greater than the unsigned 12-bit `rx_thr`, and 0 otherwise.
- R5: `tx_wm` is 1 when `occ` is less than or equal to the unsigned 12-bit `tx_thr`, and 0 otherwise.
- R6: `burst_code` sets the burst length: 0 means 1 beat, 1 means 4 beats, 2 means 8 beats, and codes 3 to 7 mean 1 beat.
- R7: With `dir_rx` = 1 and no request pending, `dma_req` rises one edge after an edge at which `occ` is at least the burst length. It stays low while `occ` is below the burst length.
- R8: With `dir_rx` = 0 and no request pending, `dma_req` rises one edge after an edge at which DEPTH minus `occ` is at least the burst length. It stays low while there is less free space than that.
- R9: Once raised, `dma_req` stays high until it has seen as many cycles with `dma_ack` = 1 as the burst length latched at its rise. It falls at the edge of the final acknowledge.
- R10: A push while `full` is 1 is dropped: contents and `occ` do not change. A pop while `empty` is 1 leaves `occ` at 0. Either event sets `err_flag` at that edge.
- R11: `err_flag` stays set until a cycle with `err_clr` = 1. If a new overrun or underrun occurs in that same cycle, the flag stays set.
- R12: A cycle with `fifo_clr` = 1 makes `occ` 0, `empty` 1, `err_flag` 0 and `dma_req` 0 at that edge. A push or pop in that cycle is discarded and does not raise an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_clr | input | 1 | Synchronous pointer, count and error clear |
| err_clr | input | 1 | Write-one-to-clear pulse for the error flag |
| wr_en | input | 1 | Push request |
| wr_data | input | DATA_W | Word to push |
| rd_en | input | 1 | Pop request |
| rd_data | output | DATA_W | Oldest stored word (valid when not empty) |
| dir_rx | input | 1 | 1: receive direction, 0: transmit direction |
| burst_code | input | 3 | DMA burst length code |
| rx_thr | input | THR_W | Receive watermark threshold |
| tx_thr | input | THR_W | Transmit watermark threshold |
| dma_ack | input | 1 | DMA beat acknowledge |
| dma_req | output | 1 | DMA burst request |
| occ | output | OCC_W | Number of stored words |
| full | output | 1 | Buffer full |
| empty | output | 1 | Buffer empty |
| rx_wm | output | 1 | Receive watermark reached |
| tx_wm | output | 1 | Transmit watermark reached |
| err_flag | output | 1 | Sticky overrun/underrun error |

## Verification
The count, head word and error flag are registered. They change at the edge that samples a push, pop or clear. `full`, `empty` and both watermark flags follow the count in the same cycle.

The DMA request is one stage later. It is decided at the edge after the count reaches a burst, so its rise is due two edges after the push that completes the burst. Its fall is due at the edge of the final acknowledge.

The bench changes inputs just after a falling edge and reads outputs at the next falling edge. Every result is therefore read half a period after the rising edge that produced it. The request checks are spaced to show both the cycle in which it is still low and the cycle in which it rises.

// File: rtl/sdh_fifo_pkg.sv
package sdh_fifo_pkg;

  localparam int BCODE_W = 3;
  localparam int BEAT_W  = 4;

  typedef enum logic {
    DMA_IDLE  = 1'b0,
    DMA_BURST = 1'b1
  } dma_st_e;

  // Burst code to beat count; codes without a defined length fall back to one beat.
  function automatic logic [BEAT_W-1:0] burst_beats(input logic [BCODE_W-1:0] code);
    logic [BEAT_W-1:0] n;
    case (code)
      3'd1:    n = BEAT_W'(4);
      3'd2:    n = BEAT_W'(8);
      default: n = BEAT_W'(1);
    endcase
    return n;
  endfunction

endpackage

// File: rtl/sdh_fifo_store.sv
module sdh_fifo_store #(
  parameter  int DATA_W = 32,
  parameter  int DEPTH  = 16,
  localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic [DATA_W-1:0] rdata,
  output logic [CW-1:0]     count,
  output logic              full,
  output logic              empty
);

  logic [AW-1:0]     wr_ptr_q, wr_ptr_d;
  logic [AW-1:0]     rd_ptr_q, rd_ptr_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic              push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push & ~full & ~clr;
  assign pop_ok  = pop & ~empty & ~clr;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (clr) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (push_ok) wr_ptr_d = ptr_inc(wr_ptr_q);
      if (pop_ok)  rd_ptr_d = ptr_inc(rd_ptr_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_d = cnt_q + CW'(1);
        2'b01:   cnt_d = cnt_q - CW'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  // Storage array: no reset, written only under its enable.
  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wr_ptr_q] <= wdata;
  end

  assign rdata = mem_q[rd_ptr_q];
  assign count = cnt_q;

endmodule

// File: rtl/sdh_fifo_wmark.sv
module sdh_fifo_wmark #(
  parameter  int CW    = 5,
  parameter  int THR_W = 12,
  localparam int XW    = (CW > THR_W) ? CW : THR_W
) (
  input  logic [CW-1:0]    count,
  input  logic [THR_W-1:0] rx_thr,
  input  logic [THR_W-1:0] tx_thr,
  output logic             rx_wm,
  output logic             tx_wm
);

  logic [XW-1:0] cnt_x, rx_x, tx_x;

  always_comb begin
    cnt_x = XW'(count);
    rx_x  = XW'(rx_thr);
    tx_x  = XW'(tx_thr);
    rx_wm = (cnt_x > rx_x);
    tx_wm = (cnt_x <= tx_x);
  end

endmodule

// File: rtl/sdh_fifo_dma.sv
module sdh_fifo_dma import sdh_fifo_pkg::*; #(
  parameter  int DEPTH = 16,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int XW    = (CW > BEAT_W) ? CW : BEAT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               dir_rx,
  input  logic [BCODE_W-1:0] burst_code,
  input  logic               ack,
  input  logic [CW-1:0]      count,
  output logic               req
);

  dma_st_e           st_q, st_d;
  logic [BEAT_W-1:0] left_q, left_d;
  logic [BEAT_W-1:0] beats;
  logic [CW-1:0]     space;
  logic [XW-1:0]     avail, need;
  logic              start;

  always_comb begin
    beats = burst_beats(burst_code);
    space = CW'(DEPTH) - count;
    avail = dir_rx ? XW'(count) : XW'(space);
    need  = XW'(beats);
    start = (avail >= need);
  end

  always_comb begin
    st_d   = st_q;
    left_d = left_q;
    if (clr) begin
      st_d   = DMA_IDLE;
      left_d = '0;
    end else begin
      case (st_q)
        DMA_IDLE: begin
          if (start) begin
            st_d   = DMA_BURST;
            left_d = beats;
          end
        end
        DMA_BURST: begin
          if (ack) begin
            if (left_q == BEAT_W'(1)) begin
              st_d   = DMA_IDLE;
              left_d = '0;
            end else begin
              left_d = left_q - BEAT_W'(1);
            end
          end
        end
        default: begin
          st_d   = DMA_IDLE;
          left_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= DMA_IDLE;
      left_q <= '0;
    end else begin
      st_q   <= st_d;
      left_q <= left_d;
    end
  end

  assign req = (st_q == DMA_BURST);

endmodule

// File: rtl/sdh_fifo_errflag.sv
module sdh_fifo_errflag (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic set,
  input  logic w1c,
  output logic err
);

  logic err_q, err_d;

  always_comb begin
    err_d = err_q;
    if (clr)      err_d = 1'b0;
    else if (set) err_d = 1'b1;
    else if (w1c) err_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign err = err_q;

endmodule

// File: rtl/sdh_data_fifo.sv
module sdh_data_fifo import sdh_fifo_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int THR_W  = 12,
  parameter int OCC_W  = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fifo_clr,
  input  logic               err_clr,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               rd_en,
  output logic [DATA_W-1:0]  rd_data,
  input  logic               dir_rx,
  input  logic [BCODE_W-1:0] burst_code,
  input  logic [THR_W-1:0]   rx_thr,
  input  logic [THR_W-1:0]   tx_thr,
  input  logic               dma_ack,
  output logic               dma_req,
  output logic [OCC_W-1:0]   occ,
  output logic               full,
  output logic               empty,
  output logic               rx_wm,
  output logic               tx_wm,
  output logic               err_flag
);

  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] count;
  logic          fault;

  sdh_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (fifo_clr),
    .push  (wr_en),
    .wdata (wr_data),
    .pop   (rd_en),
    .rdata (rd_data),
    .count (count),
    .full  (full),
    .empty (empty)
  );

  sdh_fifo_wmark #(.CW(CW), .THR_W(THR_W)) u_wmark (
    .count  (count),
    .rx_thr (rx_thr),
    .tx_thr (tx_thr),
    .rx_wm  (rx_wm),
    .tx_wm  (tx_wm)
  );

  sdh_fifo_dma #(.DEPTH(DEPTH)) u_dma (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (fifo_clr),
    .dir_rx     (dir_rx),
    .burst_code (burst_code),
    .ack        (dma_ack),
    .count      (count),
    .req        (dma_req)
  );

  assign fault = ~fifo_clr & ((wr_en & full) | (rd_en & empty));

  sdh_fifo_errflag u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (fifo_clr),
    .set   (fault),
    .w1c   (err_clr),
    .err   (err_flag)
  );

  assign occ = OCC_W'(count);

endmodule

// File: rtl/sdh_data_fifo_chk.sv
module sdh_data_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int OCC_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_clr,
  input logic             err_clr,
  input logic             wr_en,
  input logic             rd_en,
  input logic             dma_ack,
  input logic             dma_req,
  input logic [OCC_W-1:0] occ,
  input logic             full,
  input logic             empty,
  input logic             err_flag
);

  assert_occ_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !rd_en && !fifo_clr) |=> $stable(occ));

  assert_occ_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_W'(DEPTH));

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !dma_ack && !fifo_clr) |=> dma_req);

  assert_full_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !rd_en && !fifo_clr) |=> (full && occ == $past(occ)));

  assert_err_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_clr && ((wr_en && full) || (rd_en && empty))) |=> err_flag);

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr && !fifo_clr) |=> err_flag);

  assert_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (empty && !err_flag && !dma_req));

endmodule

bind sdh_data_fifo sdh_data_fifo_chk #(.DEPTH(DEPTH), .OCC_W(OCC_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .fifo_clr (fifo_clr),
  .err_clr  (err_clr),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .dma_ack  (dma_ack),
  .dma_req  (dma_req),
  .occ      (occ),
  .full     (full),
  .empty    (empty),
  .err_flag (err_flag)
);

// File: tb/test_sdh_data_fifo.sv
module test_sdh_data_fifo;

  localparam int CLK_P = 10;
  localparam int DW    = 32;
  localparam int DEPTH = 16;
  localparam int THR_W = 12;
  localparam int OCC_W = 13;

  typedef struct packed {
    logic          wr;
    logic          rd;
    logic [DW-1:0] din;
    logic [12:0]   exp_occ;
    logic [DW-1:0] exp_head;
    logic          exp_err;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 32'hA1, 13'd1, 32'hA1, 1'b0},
    '{1'b1, 1'b0, 32'hB2, 13'd2, 32'hA1, 1'b0},
    '{1'b1, 1'b1, 32'hC3, 13'd2, 32'hB2, 1'b0},
    '{1'b1, 1'b0, 32'hD4, 13'd3, 32'hB2, 1'b0},
    '{1'b0, 1'b1, 32'h00, 13'd2, 32'hC3, 1'b0},
    '{1'b0, 1'b0, 32'h00, 13'd2, 32'hC3, 1'b0},
    '{1'b0, 1'b1, 32'h00, 13'd1, 32'hD4, 1'b0},
    '{1'b0, 1'b1, 32'h00, 13'd0, 32'h00, 1'b0},
    '{1'b0, 1'b1, 32'h00, 13'd0, 32'h00, 1'b1}
  };

  logic             clk, rst_n, fifo_clr, err_clr, wr_en, rd_en;
  logic [DW-1:0]    wr_data, rd_data;
  logic             dir_rx, dma_ack, dma_req;
  logic [2:0]       burst_code;
  logic [THR_W-1:0] rx_thr, tx_thr;
  logic [OCC_W-1:0] occ;
  logic             full, empty, rx_wm, tx_wm, err_flag;

  int checks = 0;
  int errors = 0;

  sdh_data_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .THR_W(THR_W), .OCC_W(OCC_W)) i_sdh_data_fifo (
    .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr), .err_clr(err_clr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .dir_rx(dir_rx), .burst_code(burst_code), .rx_thr(rx_thr), .tx_thr(tx_thr),
    .dma_ack(dma_ack), .dma_req(dma_req), .occ(occ), .full(full), .empty(empty),
    .rx_wm(rx_wm), .tx_wm(tx_wm), .err_flag(err_flag)
  );

  initial clk = 1'b0;
  always #(CLK_P / 2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Inputs set after a falling edge are taken by the next rising edge; results are read at the falling edge after it.
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet();
    wr_en = 1'b0; rd_en = 1'b0; fifo_clr = 1'b0; err_clr = 1'b0; dma_ack = 1'b0;
  endtask

  task automatic clear_all();
    quiet(); fifo_clr = 1'b1; tick(); quiet();
  endtask

  task automatic push_one(input logic [DW-1:0] d);
    quiet(); wr_en = 1'b1; wr_data = d; tick(); quiet();
  endtask

  task automatic beat(input logic is_push);
    quiet(); dma_ack = 1'b1;
    if (is_push) begin wr_en = 1'b1; wr_data = 32'h55; end
    else rd_en = 1'b1;
    tick(); quiet();
  endtask

  initial begin
    #(CLK_P * 50000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; quiet(); wr_data = '0; dir_rx = 1'b1; burst_code = 3'd0;
    rx_thr = 12'd2; tx_thr = 12'd1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 occ", 32'(occ), 0);
    chk("R1 empty", 32'(empty), 1);
    chk("R1 full", 32'(full), 0);
    chk("R1 err_flag", 32'(err_flag), 0);
    chk("R1 dma_req", 32'(dma_req), 0);
    rst_n = 1'b1;
    tick();
    chk("R1 occ after release", 32'(occ), 0);

    // R2/R4/R5/R10: vector walk with rx_thr=2, tx_thr=1
    for (int i = 0; i < NV; i++) begin
      quiet();
      wr_en = VECS[i].wr; rd_en = VECS[i].rd; wr_data = VECS[i].din;
      tick();
      quiet();
      chk("R2 occ", 32'(occ), 32'(VECS[i].exp_occ));
      if (VECS[i].exp_occ != 0) chk("R2 head", rd_data, VECS[i].exp_head);
      chk("R10 err", 32'(err_flag), 32'(VECS[i].exp_err));
      chk("R4 rx_wm", 32'(rx_wm), 32'(VECS[i].exp_occ > 2));
      chk("R5 tx_wm", 32'(tx_wm), 32'(VECS[i].exp_occ <= 1));
    end

    // R11: sticky flag, clear pulse, and same-cycle set winning
    tick();
    chk("R11 held", 32'(err_flag), 1);
    err_clr = 1'b1; rd_en = 1'b1; tick(); quiet();
    chk("R11 set beats clear", 32'(err_flag), 1);
    err_clr = 1'b1; tick(); quiet();
    chk("R11 cleared", 32'(err_flag), 0);

    // R3/R10/R2: fill, overrun, drain in order
    clear_all();
    for (int i = 0; i < DEPTH; i++) push_one(32'(i + 100));
    chk("R3 full", 32'(full), 1);
    chk("R3 occ at depth", 32'(occ), DEPTH);
    chk("R3 not empty", 32'(empty), 0);
    push_one(32'hDEAD);
    chk("R10 overrun occ", 32'(occ), DEPTH);
    chk("R10 overrun err", 32'(err_flag), 1);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R2 drain order", rd_data, 32'(i + 100));
      quiet(); rd_en = 1'b1; tick(); quiet();
    end
    chk("R3 empty", 32'(empty), 1);
    chk("R3 occ zero", 32'(occ), 0);
    err_clr = 1'b1; tick(); quiet();
    rd_en = 1'b1; tick(); quiet();
    chk("R10 underrun err", 32'(err_flag), 1);
    chk("R10 underrun occ", 32'(occ), 0);

    // R4/R5: threshold boundaries
    clear_all();
    tx_thr = 12'd0;
    chk("R5 tx_wm at 0<=0", 32'(tx_wm), 1);
    rx_thr = 12'd3; tx_thr = 12'd3;
    for (int i = 0; i < 3; i++) push_one(32'(i));
    chk("R4 rx_wm at occ=thr", 32'(rx_wm), 0);
    chk("R5 tx_wm at occ=thr", 32'(tx_wm), 1);
    push_one(32'h3);
    chk("R4 rx_wm above thr", 32'(rx_wm), 1);
    chk("R5 tx_wm above thr", 32'(tx_wm), 0);
    rx_thr = 12'hFFF;
    #1;
    chk("R4 rx_wm max thr", 32'(rx_wm), 0);

    // R7/R9/R6: receive burst of 4
    dir_rx = 1'b1; burst_code = 3'd1;
    clear_all();
    chk("R12 req after clear", 32'(dma_req), 0);
    for (int i = 0; i < 3; i++) push_one(32'(i));
    tick();
    chk("R7 no req below burst", 32'(dma_req), 0);
    push_one(32'h3);
    chk("R7 req not yet", 32'(dma_req), 0);
    tick();
    chk("R7 req raised", 32'(dma_req), 1);
    for (int i = 0; i < 3; i++) begin
      beat(1'b0);
      chk("R9 req held", 32'(dma_req), 1);
    end
    beat(1'b0);
    chk("R9 req dropped on final ack", 32'(dma_req), 0);
    tick();
    chk("R7 no re-raise when empty", 32'(dma_req), 0);

    // R6: code 5 acts as one beat
    burst_code = 3'd5;
    push_one(32'h9);
    tick();
    chk("R6 code5 req", 32'(dma_req), 1);
    beat(1'b0);
    chk("R6 code5 one beat", 32'(dma_req), 0);

    // R6/R7: code 2 needs eight words
    burst_code = 3'd2;
    for (int i = 0; i < 7; i++) push_one(32'(i));
    tick();
    chk("R6 code2 no req at 7", 32'(dma_req), 0);
    push_one(32'h7);
    tick();
    chk("R6 code2 req at 8", 32'(dma_req), 1);

    // R8/R9: transmit direction, eight-beat bursts of free space
    dir_rx = 1'b0;
    clear_all();
    tick();
    chk("R8 req on free space", 32'(dma_req), 1);
    for (int i = 0; i < 7; i++) beat(1'b1);
    chk("R9 tx req held", 32'(dma_req), 1);
    beat(1'b1);
    chk("R9 tx req dropped", 32'(dma_req), 0);
    tick();
    chk("R8 re-raise with 8 free", 32'(dma_req), 1);
    for (int i = 0; i < 8; i++) beat(1'b1);
    chk("R8 tx full occ", 32'(occ), DEPTH);
    tick();
    chk("R8 no req without space", 32'(dma_req), 0);

    // R12: clear with a push in the same cycle
    push_one(32'hBEEF);
    chk("R12 err before clear", 32'(err_flag), 1);
    dir_rx = 1'b1; burst_code = 3'd2;
    quiet(); fifo_clr = 1'b1; wr_en = 1'b1; wr_data = 32'h77; tick(); quiet();
    chk("R12 occ", 32'(occ), 0);
    chk("R12 empty", 32'(empty), 1);
    chk("R12 err", 32'(err_flag), 0);
    chk("R12 req", 32'(dma_req), 0);
    tick();
    chk("R12 push discarded", 32'(occ), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule